// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by reading a two-level page table kept in memory. A request carries the logical address and an access kind (read, write or execute). The walker reads one entry from the outer table and then, if that entry is usable, one entry from the inner table it names. It then returns either the physical address or a code that says which check failed. Software programs two plain registers: the physical base of the outer table and the number of outer entries that are in use.

The logical address is split from the top bit down into three fields: a 12-bit outer index, a 10-bit inner index and a 10-bit offset within a 1 KB page. Every table entry is 4 bytes wide. Bit 0 of each entry is its valid bit. An outer entry carries the 4 KB-aligned base of an inner table in bits 31:12. An inner entry carries the frame number in bits 31:10 and a protection field in bits 2:1.

The request, memory-read and result interfaces all use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the walker is idle. A memory read is issued on a cycle where `mem_rd_valid` and `mem_rd_ready` are both high. Its data arrives later as a one-cycle `mem_rsp_valid` pulse, and the walker cannot stall that response. The result stays on the outputs until the consumer raises `rsp_ready`.

Top module: `pt2_walker`

## Requirements
- R1: For a translation that passes every check, `rsp_paddr` is the inner entry's bits 31:10 followed by the 10 offset bits of the logical address, and `rsp_fault` is 0.
- R2: The outer entry is read from `cfg_base` plus 4 times the outer index, where `cfg_base` is sampled when the request is accepted. The inner entry is read from the outer entry's bits 31:12 shifted left by 12, plus 4 times the inner index.
- R3: If the outer index is greater than or equal to `cfg_len`, the result is fault code 1 and no memory read is issued.
- R4: If bit 0 of the outer entry is 0, the result is fault code 2 and the inner table is not read.
- R5: If bit 0 of the inner entry is 0, the result is fault code 3. This includes virtual page 0, which is kept invalid so that a null-pointer access faults.
- R6: The inner entry's bits 2:1 encode the protection: 0 read-only, 1 read-write, 2 execute-only, 3 no access. Access codes are 0 read, 1 write, 2 execute and 3 reserved. Reserved is allowed on no page. An access the protection does not allow gives fault code 4. Whenever the fault code is not 0, `rsp_paddr` is 0.
- R7: `req_ready` is high only while the walker is idle, with no memory read and no result pending. Only one request is in flight at a time.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_paddr` and `rsp_fault` hold their values.
- R9: A memory read request keeps `mem_rd_valid` high and its address unchanged until it is accepted. The walk continues only on the response that follows an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 32 | Physical base address of the outer table |
| cfg_len | input | 13 | Number of outer entries in use (0 to 4096) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can take a request |
| req_vaddr | input | 32 | Logical address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| mem_rd_valid | output | 1 | Memory read request present |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present (one-cycle pulse, cannot be stalled) |
| mem_rsp_data | input | 32 | Entry word read from memory |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address, 0 when faulted |
| rsp_fault | output | 3 | 0 ok, 1 bounds, 2 outer invalid, 3 inner invalid, 4 permission |

## Verification
The hardest case to reach from the ports is a read request held by memory back-pressure across several cycles while the walker sits between its two levels. The bench's memory model can stall, so it accepts reads only one cycle in four, and the whole vector table is replayed in that mode. The bench counts accepted reads for each request and compares the count with the depth the walk should reach: zero reads for a bounds fault, one for an outer-invalid fault, two otherwise. That count shows a walk stopped where it had to. Moving the outer base forces the memory model to decode a different region, so a wrongly formed entry address returns garbage and the check fails.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 32;
  localparam int OIDX_W = 12;
  localparam int IIDX_W = 10;
  localparam int OFF_W  = 10;
  localparam int ENT_LG = 2;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_BOUND = 3'd1,
    FLT_OUTER = 3'd2,
    FLT_INNER = 3'd3,
    FLT_PERM  = 3'd4
  } fault_e;

  typedef enum logic [1:0] {ACC_RD = 2'd0, ACC_WR = 2'd1, ACC_EX = 2'd2, ACC_RSV = 2'd3} acc_e;
  typedef enum logic [1:0] {PRM_RO = 2'd0, PRM_RW = 2'd1, PRM_XO = 2'd2, PRM_NONE = 2'd3} perm_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W   = ptw_pkg::VA_W,
  parameter int PA_W   = ptw_pkg::PA_W,
  parameter int OIDX_W = ptw_pkg::OIDX_W,
  parameter int IIDX_W = ptw_pkg::IIDX_W,
  parameter int OFF_W  = ptw_pkg::OFF_W,
  parameter int ENT_LG = ptw_pkg::ENT_LG,
  localparam int IN_AL = IIDX_W + ENT_LG
) (
  input  logic [VA_W-1:0]       va,
  input  logic [PA_W-1:0]       tbl_base,
  input  logic [PA_W-IN_AL-1:0] inner_base,
  output logic [OIDX_W-1:0]     oidx,
  output logic [PA_W-1:0]       outer_addr,
  output logic [PA_W-1:0]       inner_addr
);
  logic [IIDX_W-1:0] iidx;

  assign oidx = va[VA_W-1 -: OIDX_W];
  assign iidx = va[OFF_W +: IIDX_W];

  assign outer_addr = tbl_base + (PA_W'(oidx) << ENT_LG);
  assign inner_addr = {inner_base, {IN_AL{1'b0}}} + (PA_W'(iidx) << ENT_LG);
endmodule

// File: rtl/ptw_perm_chk.sv
module ptw_perm_chk
  import ptw_pkg::*;
(
  input  logic [1:0] perm,
  input  logic [1:0] acc,
  output logic       allow
);
  always_comb begin
    unique case (acc_e'(acc))
      ACC_RD:  allow = (perm_e'(perm) == PRM_RO) || (perm_e'(perm) == PRM_RW);
      ACC_WR:  allow = (perm_e'(perm) == PRM_RW);
      ACC_EX:  allow = (perm_e'(perm) == PRM_XO);
      default: allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/pt2_walker.sv
module pt2_walker
  import ptw_pkg::*;
#(
  parameter int VA_W   = ptw_pkg::VA_W,
  parameter int PA_W   = ptw_pkg::PA_W,
  parameter int OIDX_W = ptw_pkg::OIDX_W,
  parameter int IIDX_W = ptw_pkg::IIDX_W,
  parameter int OFF_W  = ptw_pkg::OFF_W,
  parameter int ENT_LG = ptw_pkg::ENT_LG,
  localparam int IN_AL = IIDX_W + ENT_LG,
  localparam int FRM_W = PA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   cfg_base,
  input  logic [OIDX_W:0]   cfg_len,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_acc,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [PA_W-1:0]   mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [PA_W-1:0]   mem_rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [2:0]        rsp_fault
);
  typedef enum logic [1:0] {ST_IDLE, ST_OUTER, ST_INNER, ST_DONE} st_e;

  st_e                  st_q;
  logic [VA_W-1:0]      va_q;
  logic [1:0]           acc_q;
  logic [PA_W-1:0]      base_q;
  logic [PA_W-IN_AL-1:0] ibase_q;
  logic                 sent_q;
  logic [PA_W-1:0]      paddr_q;
  fault_e               fault_q;

  logic [OIDX_W-1:0]    oidx_new, oidx_held;
  logic [PA_W-1:0]      outer_addr, inner_addr, unused_addr;
  logic                 allow;
  logic                 rsp_take;
  logic                 unused_rsvd;

  // index of the incoming request, for the bounds test at acceptance
  ptw_addr_gen #(.VA_W(VA_W), .PA_W(PA_W), .OIDX_W(OIDX_W), .IIDX_W(IIDX_W),
                 .OFF_W(OFF_W), .ENT_LG(ENT_LG)) u_gen_new (
    .va(req_vaddr), .tbl_base(cfg_base), .inner_base(ibase_q),
    .oidx(oidx_new), .outer_addr(unused_addr), .inner_addr()
  );

  // entry addresses of the request in flight
  ptw_addr_gen #(.VA_W(VA_W), .PA_W(PA_W), .OIDX_W(OIDX_W), .IIDX_W(IIDX_W),
                 .OFF_W(OFF_W), .ENT_LG(ENT_LG)) u_gen_cur (
    .va(va_q), .tbl_base(base_q), .inner_base(ibase_q),
    .oidx(oidx_held), .outer_addr(outer_addr), .inner_addr(inner_addr)
  );

  ptw_perm_chk u_perm (
    .perm(mem_rsp_data[2:1]), .acc(acc_q), .allow(allow)
  );

  assign unused_rsvd = ^{mem_rsp_data[OFF_W-1:3], unused_addr, oidx_held};

  assign req_ready    = (st_q == ST_IDLE);
  assign mem_rd_valid = ((st_q == ST_OUTER) || (st_q == ST_INNER)) && !sent_q;
  assign mem_rd_addr  = (st_q == ST_INNER) ? inner_addr : outer_addr;
  assign rsp_take     = sent_q && mem_rsp_valid;
  assign rsp_valid    = (st_q == ST_DONE);
  assign rsp_paddr    = paddr_q;
  assign rsp_fault    = fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      acc_q   <= '0;
      base_q  <= '0;
      ibase_q <= '0;
      sent_q  <= 1'b0;
      paddr_q <= '0;
      fault_q <= FLT_NONE;
    end else begin
      if (mem_rd_valid && mem_rd_ready) sent_q <= 1'b1;
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          acc_q   <= req_acc;
          base_q  <= cfg_base;
          sent_q  <= 1'b0;
          paddr_q <= '0;
          if ({1'b0, oidx_new} >= cfg_len) begin
            fault_q <= FLT_BOUND;
            st_q    <= ST_DONE;
          end else begin
            st_q <= ST_OUTER;
          end
        end
        ST_OUTER: if (rsp_take) begin
          sent_q <= 1'b0;
          if (!mem_rsp_data[0]) begin
            fault_q <= FLT_OUTER;
            st_q    <= ST_DONE;
          end else begin
            ibase_q <= mem_rsp_data[PA_W-1:IN_AL];
            st_q    <= ST_INNER;
          end
        end
        ST_INNER: if (rsp_take) begin
          sent_q <= 1'b0;
          st_q   <= ST_DONE;
          if (!mem_rsp_data[0])  fault_q <= FLT_INNER;
          else if (!allow)       fault_q <= FLT_PERM;
          else begin
            fault_q <= FLT_NONE;
            paddr_q <= {mem_rsp_data[PA_W-1 -: FRM_W], va_q[OFF_W-1:0]};
          end
        end
        ST_DONE: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt2_walker_chk.sv
module pt2_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [12:0] cfg_len,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_vaddr,
  input logic        mem_rd_valid,
  input logic        mem_rd_ready,
  input logic [31:0] mem_rd_addr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_paddr,
  input logic [2:0]  rsp_fault
);
  // R2
  entry_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (mem_rd_addr[1:0] == 2'b00));

  // R3
  bound_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ({1'b0, req_vaddr[31:20]} >= cfg_len))
      |=> (!mem_rd_valid && rsp_valid && rsp_fault == 3'd1));

  // R6
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 3'd0) |-> (rsp_paddr == 32'd0));

  // R7
  idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mem_rd_valid));

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
endmodule

bind pt2_walker pt2_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .req_valid(req_valid),
  .req_ready(req_ready), .req_vaddr(req_vaddr), .mem_rd_valid(mem_rd_valid),
  .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
);

// File: tb/tb_pt2_walker.sv
`timescale 1ns/1ps
module tb_pt2_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_base = 32'h0001_0000;
  logic [12:0] cfg_len = 13'd10;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        mem_rd_valid, mem_rd_ready;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_fault;

  int n_chk = 0, n_bad = 0, mem_reads = 0;
  logic       stall_en = 1'b0;
  logic [1:0] cyc = '0;

  always #2 clk = ~clk;

  pt2_walker dut (.*);

  // memory image: outer table at cfg_base, entries 0..7 valid except 5,
  // inner table k at 0x0010_0000 + k*0x1000; inner entry j valid unless
  // (k,j)=(0,0) or j=7; protection j%3; frame {2'b10, k[9:0], j[9:0]}
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] k, j;
    if (a >= cfg_base && a < cfg_base + 32'h4000) begin
      k = (a - cfg_base) >> 2;
      if (k < 8 && k != 5) return {20'h00100 + k[19:0], 11'h0, 1'b1};
      return 32'h0000_1000;
    end else if (a >= 32'h0010_0000 && a < 32'h0010_8000) begin
      k = (a - 32'h0010_0000) >> 12;
      j = (a >> 2) & 32'h3FF;
      return {2'b10, k[9:0], j[9:0], 7'h0, 2'(j % 3),
              !((k == 0 && j == 0) || j == 7)};
    end
    return 32'hDEAD_BEEF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      mem_rd_ready  <= 1'b1;
    end else begin
      mem_rsp_valid <= mem_rd_valid && mem_rd_ready;
      mem_rsp_data  <= mem_word(mem_rd_addr);
      if (mem_rd_valid && mem_rd_ready) mem_reads <= mem_reads + 1;
      mem_rd_ready  <= !stall_en || (cyc == 2'b11);
      cyc <= cyc + 2'd1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] va, input logic [1:0] acc);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] va, input logic [1:0] acc,
                       output logic [31:0] pa, output logic [2:0] flt, output int reads);
    int r0;
    r0 = mem_reads;
    issue(va, acc);
    while (!rsp_valid) @(negedge clk);
    pa = rsp_paddr; flt = rsp_fault;
    @(negedge clk);
    reads = mem_reads - r0;
  endtask

  // {acc, vaddr, expected fault}
  localparam logic [36:0] VECS [13] = '{
    {2'd0, 12'd1,    10'd0,    10'h155, 3'd0},  // R1 read of read-only
    {2'd1, 12'd1,    10'd0,    10'h155, 3'd4},  // R6 write to read-only
    {2'd1, 12'd2,    10'd1,    10'h0AA, 3'd0},  // R6 write to read-write
    {2'd2, 12'd3,    10'd2,    10'h001, 3'd0},  // R6 execute of execute-only
    {2'd0, 12'd3,    10'd2,    10'h001, 3'd4},  // R6 read of execute-only
    {2'd0, 12'd0,    10'd0,    10'h000, 3'd3},  // R5 null page
    {2'd0, 12'd4,    10'd7,    10'h010, 3'd3},  // R5 invalid inner
    {2'd0, 12'd5,    10'd3,    10'h020, 3'd2},  // R4 invalid outer
    {2'd0, 12'd9,    10'd4,    10'h030, 3'd2},  // R4 invalid outer, in bound
    {2'd0, 12'd10,   10'd4,    10'h030, 3'd1},  // R3 first index out of bound
    {2'd2, 12'd4095, 10'd1023, 10'h3FF, 3'd1},  // R3 top index
    {2'd0, 12'd7,    10'd1023, 10'h3FF, 3'd0},  // R1 last page, last byte
    {2'd3, 12'd2,    10'd1,    10'h000, 3'd4}   // R6 reserved access code
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] pa, epa, va;
    logic [2:0]  flt, ef;
    int          rd, erd;
    repeat (3) @(negedge clk);
    check("R7 reset req_ready", {31'd0, req_ready}, 32'd1);
    check("R7 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R9 reset mem_rd_valid", {31'd0, mem_rd_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int p = 0; p < 2; p++) begin
      stall_en = (p == 1);
      for (int k = 0; k < 13; k++) begin
        va = VECS[k][34:3];
        ef = VECS[k][2:0];
        epa = (ef == 3'd0) ? {2'b10, va[29:0]} : 32'd0;
        erd = (ef == 3'd1) ? 0 : (ef == 3'd2) ? 1 : 2;
        xlate(va, VECS[k][36:35], pa, flt, rd);
        check(p ? "R9 stalled fault" : "R1 R4 R5 R6 fault", {29'd0, flt}, {29'd0, ef});
        check(p ? "R9 stalled paddr" : "R1 R6 paddr", pa, epa);
        check("R3 R4 read count", rd, erd);
      end
    end
    stall_en = 1'b0;

    // R7: busy walker refuses a second request
    issue({12'd1, 10'd0, 10'd0}, 2'd0);
    check("R7 req_ready while busy", {31'd0, req_ready}, 32'd0);
    while (!rsp_valid) @(negedge clk);
    @(negedge clk);

    // R8: result held under back-pressure
    rsp_ready = 1'b0;
    issue({12'd2, 10'd4, 10'h12}, 2'd0);
    while (!rsp_valid) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R8 held valid", {31'd0, rsp_valid}, 32'd1);
    check("R8 held paddr", rsp_paddr, {2'b10, 10'd2, 10'd4, 10'h12});
    check("R8 held fault", {29'd0, rsp_fault}, 32'd0);
    check("R7 no accept while result pending", {31'd0, req_ready}, 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R8 released", {31'd0, rsp_valid}, 32'd0);

    // R2: relocated outer table
    cfg_base = 32'h0003_0000;
    xlate({12'd6, 10'd5, 10'h2C}, 2'd2, pa, flt, rd);
    check("R2 relocated base paddr", pa, {2'b10, 10'd6, 10'd5, 10'h2C});
    check("R2 relocated base fault", {29'd0, flt}, 32'd0);

    // R3: zero length blocks every index
    cfg_len = 13'd0;
    xlate({12'd0, 10'd3, 10'h0}, 2'd0, pa, flt, rd);
    check("R3 zero length fault", {29'd0, flt}, 32'd1);
    check("R3 zero length reads", rd, 0);
    cfg_len = 13'd4096;
    xlate({12'd4095, 10'd3, 10'h0}, 2'd0, pa, flt, rd);
    check("R3 full length reaches outer", {29'd0, flt}, 32'd2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule